// File: doc/BRIEF.md
# Disk Controller Data-Transfer FIFO Engine

This block carries sector data between a host bus and a disk-side byte serializer through a small byte FIFO. A command pulse opens an execution phase. On a write command, the host fills the FIFO and the serializer draws one byte per strobe. After each sector's data bytes the engine emits a 16-bit CRC. On a read command, the serializer pushes bytes and the host removes them. When the last byte has been exchanged, the engine moves to a result phase. That phase lasts until the next command.

The host reaches the FIFO in two ways. The first is programmed I/O, which needs the chip select and the data-port address and is paced by the request-for-master and direction status outputs. The second is a DMA acknowledge strobe, which bypasses address decode. The engine raises its DMA request once the FIFO holds enough bytes, or enough free space, to meet a programmable threshold.

When the serializer finds the FIFO full on a read, the engine flags an overrun. When the serializer finds it empty on a write, it flags an underrun. Either event ends the transfer cleanly. A write that ends early still completes its current sector with zero fill and a correct CRC. A read that ends early waits for the host to drain the FIFO before it enters the result phase.

A byte mode limits the FIFO to a single entry. In byte mode, a verify option turns each acknowledge strobe on a read into a pseudo-read that discards the byte.

Top module: `fdcXferEngine`

## Requirements
- R1: A `cmdStart` pulse empties the FIFO, clears both error flags and enters the execution phase. Bytes written during an earlier command are never sent.
- R2: On a write command, every sector puts SECTOR_BYTES host bytes on `serData` in write order, one per `serTake`. Two CRC bytes follow, high byte first. The CRC is CCITT (polynomial 0x1021), preset to 0xFFFF at the start of each sector, and processes each byte most significant bit first.
- R3: On a write, a `serTake` for a data byte while the FIFO is empty sets `underrun`. That byte and every remaining data byte of the sector are 0x00. The sector's CRC covers the bytes actually sent. The result phase follows that sector's CRC, and no further sector is sent.
- R4: On a read command, bytes from `serPut` reach the host in arrival order. `resultPhase` rises only after every byte has been delivered and the FIFO is empty.
- R5: On a read, a `serPut` while the FIFO holds its effective depth sets `overrun` and drops the byte. Later `serPut` strobes are ignored. The result phase waits until the host has removed the bytes still in the FIFO.
- R6: `rqm` is 1 during a write while the FIFO has room, host bytes are still owed and no error has occurred. During a read, `rqm` is 1 while the FIFO holds a byte. It is 0 outside the execution phase. `dio` is 1 during the execution phase of a read. A programmed-I/O access made while `rqm` is 0 is ignored.
- R7: With DMA enabled, `drq` behaves as follows. On a write, it is 1 when `rqm` is 1 and the free space is at least min(threshold, host bytes owed). On a read, it is 1 when the FIFO count is at least min(threshold, host bytes owed), or, after an overrun, whenever the FIFO is not empty. A threshold of 0 is treated as 1.
- R8: Programmed I/O needs `hostCs` high and `hostAddr` equal to DATA_ADDR (default 5). A `dack` access needs neither and reaches the FIFO whatever `hostAddr` holds.
- R9: With `cfgFifoOn` at 0 (byte mode), the FIFO holds at most one byte and the threshold is 1.
- R10: In byte mode with `cfgVerify` set on a read, each `dack` pulse removes one byte and counts it as transferred. No host read strobe is needed, and `hostRData` stays 0x00.
- R11: A write command without error enters the result phase on the `serTake` of the last sector's low CRC byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | Pulse: start execution phase, latch configuration |
| cmdRead | input | 1 | 1 = drive-to-host read command, 0 = write |
| cmdSectors | input | 4 | Number of sectors (1 to 15) |
| cfgDma | input | 1 | DMA request enable |
| cfgFifoOn | input | 1 | 1 = FIFO mode, 0 = byte mode |
| cfgVerify | input | 1 | DMA verify (pseudo-read) in byte mode |
| cfgThresh | input | $clog2(DEPTH+1) | DMA threshold in bytes |
| hostCs | input | 1 | Programmed-I/O chip select |
| hostAddr | input | 3 | Programmed-I/O register address |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| dack | input | 1 | DMA acknowledge |
| hostWData | input | 8 | Host write data |
| hostRData | output | 8 | Host read data (0 when no read is accepted) |
| rqm | output | 1 | Request for master |
| dio | output | 1 | Direction, 1 = drive to host |
| drq | output | 1 | DMA request |
| serTake | input | 1 | Serializer consumes the byte on serData |
| serData | output | 8 | Byte offered to the serializer |
| serPut | input | 1 | Serializer delivers serInData |
| serInData | input | 8 | Byte from the serializer |
| execActive | output | 1 | Execution phase |
| resultPhase | output | 1 | Result phase |
| overrun | output | 1 | Overrun flag |
| underrun | output | 1 | Underrun flag |

## Verification
Several properties are checked on every cycle. A command start must leave the FIFO empty with both flags clear, and `rqm` must never coincide with the result phase. Once underrun is set, no FIFO byte is popped toward the serializer. An overrun may rise only on a serializer delivery. A read may enter its result phase only with the FIFO empty. A read-side `drq` requires a byte in the FIFO. Only the bench scenarios can show byte order, CRC values, the zero fill after underrun at every byte position, threshold-dependent `drq` timing, address-free acknowledge access and the verify pseudo-read.

// File: rtl/fdcXferPkg.sv
package fdcXferPkg;

  typedef enum logic [1:0] {
    SEL_FIFO   = 2'd0,
    SEL_ZERO   = 2'd1,
    SEL_CRC_HI = 2'd2,
    SEL_CRC_LO = 2'd3
  } outSel_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_EXEC   = 2'd1,
    PH_RESULT = 2'd2
  } phase_e;

  typedef struct packed {
    logic    flush;
    logic    push;
    logic    pushFromSer;
    logic    pop;
    logic    readOut;
    logic    crcInit;
    logic    crcUpdate;
    outSel_e outSel;
  } dpStrobes_t;

  function automatic logic [15:0] crcStep(input logic [15:0] crcIn, input logic [7:0] dataIn);
    logic [15:0] acc;
    logic fb;
    acc = crcIn;
    for (int i = 7; i >= 0; i--) begin
      fb  = acc[15] ^ dataIn[i];
      acc = {acc[14:0], 1'b0};
      if (fb) acc = acc ^ 16'h1021;
    end
    return acc;
  endfunction

endpackage

// File: rtl/fdcXferFifo.sv
module fdcXferFifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wData,
  output logic [W-1:0]  rData,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign rData  = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wData;
  end

endmodule

// File: rtl/fdcXferDatapath.sv
module fdcXferDatapath
  import fdcXferPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobes_t    strb,
  input  logic [7:0]    hostWData,
  input  logic [7:0]    serInData,
  output logic [7:0]    hostRData,
  output logic [7:0]    serData,
  output logic [CW-1:0] fifoCount
);

  logic [7:0]  headByte;
  logic [7:0]  pushByte;
  logic [15:0] crcReg;

  assign pushByte = strb.pushFromSer ? serInData : hostWData;

  fdcXferFifo #(.DEPTH(DEPTH), .W(8)) uFifo (
    .clk   (clk),
    .rstN  (rstN),
    .flush (strb.flush),
    .push  (strb.push),
    .pop   (strb.pop),
    .wData (pushByte),
    .rData (headByte),
    .count (fifoCount)
  );

  always_comb begin
    case (strb.outSel)
      SEL_FIFO:   serData = headByte;
      SEL_ZERO:   serData = 8'h00;
      SEL_CRC_HI: serData = crcReg[15:8];
      default:    serData = crcReg[7:0];
    endcase
  end

  assign hostRData = strb.readOut ? headByte : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               crcReg <= 16'hFFFF;
    else if (strb.crcInit)   crcReg <= 16'hFFFF;
    else if (strb.crcUpdate) crcReg <= crcStep(crcReg, serData);
  end

endmodule

// File: rtl/fdcXferControl.sv
module fdcXferControl
  import fdcXferPkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int SECTOR_BYTES = 8,
  parameter int DATA_ADDR    = 5,
  localparam int CW          = $clog2(DEPTH + 1),
  localparam int BW          = $clog2(SECTOR_BYTES + 2),
  localparam int TW          = $clog2(15 * SECTOR_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdStart,
  input  logic          cmdRead,
  input  logic [3:0]    cmdSectors,
  input  logic          cfgDma,
  input  logic          cfgFifoOn,
  input  logic          cfgVerify,
  input  logic [CW-1:0] cfgThresh,
  input  logic          hostCs,
  input  logic [2:0]    hostAddr,
  input  logic          hostRd,
  input  logic          hostWr,
  input  logic          dack,
  input  logic          serTake,
  input  logic          serPut,
  input  logic [CW-1:0] fifoCount,
  output dpStrobes_t    strb,
  output logic          rqm,
  output logic          dio,
  output logic          drq,
  output logic          execActive,
  output logic          resultPhase,
  output logic          overrun,
  output logic          underrun
);

  phase_e        phase;
  logic          isRead, dmaOn, fifoOn, verOn;
  logic [CW-1:0] thrReg;
  logic [TW-1:0] hostRemain, serRemain;
  logic [BW-1:0] byteIdx;
  logic [3:0]    sectorsLeft;

  logic          exec, aborted, empty, full, verifyPath, pioSel;
  logic [CW-1:0] effDepth, effThr, freeSpace;
  logic [31:0]   needBytes;
  logic          inData, atCrcHi, atCrcLo;
  logic          hostWrAcc, readAcc, serTakeAcc, serPopAcc, underSet;
  logic          serPutTry, serPutAcc, overSet, readDone;
  logic          rqmWr, rqmRd;

  assign exec       = (phase == PH_EXEC);
  assign aborted    = overrun | underrun;
  assign effDepth   = fifoOn ? CW'(DEPTH) : CW'(1);
  assign effThr     = !fifoOn ? CW'(1) : ((thrReg == '0) ? CW'(1) : thrReg);
  assign empty      = (fifoCount == '0);
  assign full       = (fifoCount >= effDepth);
  assign freeSpace  = effDepth - fifoCount;
  assign verifyPath = verOn & ~fifoOn;
  assign pioSel     = hostCs && (hostAddr == 3'(DATA_ADDR));

  assign needBytes  = (32'(hostRemain) < 32'(effThr)) ? 32'(hostRemain) : 32'(effThr);

  assign inData     = (byteIdx < BW'(SECTOR_BYTES));
  assign atCrcHi    = (byteIdx == BW'(SECTOR_BYTES));
  assign atCrcLo    = (byteIdx == BW'(SECTOR_BYTES + 1));

  assign rqmWr      = exec & ~isRead & ~aborted & (hostRemain != '0) & ~full;
  assign rqmRd      = exec & isRead & ~empty;
  assign rqm        = rqmWr | rqmRd;
  assign dio        = exec & isRead;
  assign execActive = exec;
  assign resultPhase = (phase == PH_RESULT);

  assign hostWrAcc  = rqmWr & hostWr & (dack | pioSel);
  assign readAcc    = rqmRd & (verifyPath ? dack : (hostRd & (dack | pioSel)));

  assign serTakeAcc = serTake & exec & ~isRead;
  assign serPopAcc  = serTakeAcc & inData & ~aborted & ~empty;
  assign underSet   = serTakeAcc & inData & ~aborted & empty;

  assign serPutTry  = serPut & exec & isRead & ~aborted & (serRemain != '0);
  assign serPutAcc  = serPutTry & ~full;
  assign overSet    = serPutTry & full;

  assign readDone   = exec & isRead & ((serRemain == '0) | aborted) & empty;

  always_comb begin
    if (!exec || isRead) drq = 1'b0;
    else                 drq = dmaOn & rqmWr & (32'(freeSpace) >= needBytes);
    if (exec && isRead && dmaOn && !empty)
      drq = aborted | (32'(fifoCount) >= needBytes);
  end

  always_comb begin
    strb = '0;
    if (inData)       strb.outSel = (aborted || empty) ? SEL_ZERO : SEL_FIFO;
    else if (atCrcHi) strb.outSel = SEL_CRC_HI;
    else              strb.outSel = SEL_CRC_LO;
    if (cmdStart) begin
      strb.flush   = 1'b1;
      strb.crcInit = 1'b1;
    end else begin
      strb.push        = hostWrAcc | serPutAcc;
      strb.pushFromSer = serPutAcc;
      strb.pop         = readAcc | serPopAcc;
      strb.readOut     = readAcc & ~verifyPath;
      strb.crcUpdate   = serTakeAcc & inData;
      strb.crcInit     = serTakeAcc & atCrcLo;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      isRead      <= 1'b0;
      dmaOn       <= 1'b0;
      fifoOn      <= 1'b1;
      verOn       <= 1'b0;
      thrReg      <= '0;
      hostRemain  <= '0;
      serRemain   <= '0;
      byteIdx     <= '0;
      sectorsLeft <= '0;
      overrun     <= 1'b0;
      underrun    <= 1'b0;
    end else if (cmdStart) begin
      phase       <= PH_EXEC;
      isRead      <= cmdRead;
      dmaOn       <= cfgDma;
      fifoOn      <= cfgFifoOn;
      verOn       <= cfgVerify;
      thrReg      <= cfgThresh;
      hostRemain  <= TW'(cmdSectors) * TW'(SECTOR_BYTES);
      serRemain   <= TW'(cmdSectors) * TW'(SECTOR_BYTES);
      byteIdx     <= '0;
      sectorsLeft <= cmdSectors;
      overrun     <= 1'b0;
      underrun    <= 1'b0;
    end else begin
      if (hostWrAcc || readAcc) hostRemain <= hostRemain - TW'(1);
      if (serPutAcc)            serRemain  <= serRemain - TW'(1);
      if (overSet)              overrun    <= 1'b1;
      if (underSet)             underrun   <= 1'b1;
      if (readDone)             phase      <= PH_RESULT;
      if (serTakeAcc) begin
        if (atCrcLo) begin
          byteIdx     <= '0;
          sectorsLeft <= sectorsLeft - 4'd1;
          if (aborted || sectorsLeft <= 4'd1) phase <= PH_RESULT;
        end else begin
          byteIdx <= byteIdx + BW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/fdcXferEngine.sv
module fdcXferEngine
  import fdcXferPkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int SECTOR_BYTES = 8,
  parameter int DATA_ADDR    = 5,
  localparam int CW          = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdStart,
  input  logic          cmdRead,
  input  logic [3:0]    cmdSectors,
  input  logic          cfgDma,
  input  logic          cfgFifoOn,
  input  logic          cfgVerify,
  input  logic [CW-1:0] cfgThresh,
  input  logic          hostCs,
  input  logic [2:0]    hostAddr,
  input  logic          hostRd,
  input  logic          hostWr,
  input  logic          dack,
  input  logic [7:0]    hostWData,
  output logic [7:0]    hostRData,
  output logic          rqm,
  output logic          dio,
  output logic          drq,
  input  logic          serTake,
  output logic [7:0]    serData,
  input  logic          serPut,
  input  logic [7:0]    serInData,
  output logic          execActive,
  output logic          resultPhase,
  output logic          overrun,
  output logic          underrun
);

  dpStrobes_t    strb;
  logic [CW-1:0] fifoCount;

  fdcXferControl #(
    .DEPTH(DEPTH), .SECTOR_BYTES(SECTOR_BYTES), .DATA_ADDR(DATA_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdStart(cmdStart), .cmdRead(cmdRead), .cmdSectors(cmdSectors),
    .cfgDma(cfgDma), .cfgFifoOn(cfgFifoOn), .cfgVerify(cfgVerify), .cfgThresh(cfgThresh),
    .hostCs(hostCs), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr), .dack(dack),
    .serTake(serTake), .serPut(serPut), .fifoCount(fifoCount),
    .strb(strb), .rqm(rqm), .dio(dio), .drq(drq),
    .execActive(execActive), .resultPhase(resultPhase),
    .overrun(overrun), .underrun(underrun)
  );

  fdcXferDatapath #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostWData(hostWData), .serInData(serInData),
    .hostRData(hostRData), .serData(serData), .fifoCount(fifoCount)
  );

endmodule

// File: rtl/fdcXferChecker.sv
module fdcXferChecker
  import fdcXferPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdStart,
  input logic          serPut,
  input logic          rqm,
  input logic          dio,
  input logic          drq,
  input logic          resultPhase,
  input logic          overrun,
  input logic          underrun,
  input logic [CW-1:0] fifoCount,
  input dpStrobes_t    strb
);

  assert_flush_on_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> (fifoCount == '0) && !overrun && !underrun);

  assert_no_pop_after_underrun_R3: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> !strb.pop || dio);

  assert_read_result_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(resultPhase) && $past(dio)) |-> (fifoCount == '0));

  assert_overrun_on_put_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(serPut) && $past(fifoCount) != '0));

  assert_rqm_not_in_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rqm && resultPhase));

  assert_read_drq_has_byte_R7: assert property (@(posedge clk) disable iff (!rstN)
    (drq && dio) |-> (fifoCount != '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(DEPTH));

endmodule

bind fdcXferEngine fdcXferChecker #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .serPut(serPut),
  .rqm(rqm), .dio(dio), .drq(drq), .resultPhase(resultPhase),
  .overrun(overrun), .underrun(underrun), .fifoCount(fifoCount), .strb(strb)
);

// File: tb/tb_fdcXferEngine.sv
`timescale 1ns/1ps
module tb_fdcXferEngine;

  localparam int DEPTH = 16;
  localparam int SB    = 8;
  localparam int DADDR = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 0, cmdRead = 0, cfgDma = 0, cfgFifoOn = 1, cfgVerify = 0;
  logic [3:0] cmdSectors = 4'd1;
  logic [4:0] cfgThresh = 5'd1;
  logic hostCs = 0, hostRd = 0, hostWr = 0, dack = 0, serTake = 0, serPut = 0;
  logic [2:0] hostAddr = 3'd0;
  logic [7:0] hostWData = 8'h00, serInData = 8'h00;
  logic [7:0] hostRData, serData;
  logic rqm, dio, drq, execActive, resultPhase, overrun, underrun;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fdcXferEngine #(.DEPTH(DEPTH), .SECTOR_BYTES(SB), .DATA_ADDR(DADDR)) dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdRead(cmdRead), .cmdSectors(cmdSectors),
    .cfgDma(cfgDma), .cfgFifoOn(cfgFifoOn), .cfgVerify(cfgVerify), .cfgThresh(cfgThresh),
    .hostCs(hostCs), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr), .dack(dack),
    .hostWData(hostWData), .hostRData(hostRData), .rqm(rqm), .dio(dio), .drq(drq),
    .serTake(serTake), .serData(serData), .serPut(serPut), .serInData(serInData),
    .execActive(execActive), .resultPhase(resultPhase), .overrun(overrun), .underrun(underrun)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crcOf(input logic [7:0] bytes [SB]);
    logic [15:0] c = 16'hFFFF;
    for (int b = 0; b < SB; b++)
      for (int i = 7; i >= 0; i--) begin
        logic top = c[15] ^ bytes[b][i];
        c = {c[14:0], 1'b0} ^ (top ? 16'h1021 : 16'h0000);
      end
    return c;
  endfunction

  task automatic startCmd(input bit rd, input int nsec, input bit dma, input bit fon,
                          input bit ver, input int thr);
    @(negedge clk);
    cmdRead = rd; cmdSectors = 4'(nsec); cfgDma = dma; cfgFifoOn = fon;
    cfgVerify = ver; cfgThresh = 5'(thr); cmdStart = 1;
    @(negedge clk);
    cmdStart = 0;
  endtask

  task automatic pioWr(input logic [7:0] d, input logic [2:0] a);
    @(negedge clk);
    hostCs = 1; hostAddr = a; hostWr = 1; hostWData = d;
    @(negedge clk);
    hostCs = 0; hostWr = 0;
  endtask

  task automatic dackWr(input logic [7:0] d);
    @(negedge clk);
    dack = 1; hostAddr = 3'd2; hostWr = 1; hostWData = d;
    @(negedge clk);
    dack = 0; hostWr = 0;
  endtask

  task automatic pioRd(output logic [7:0] d);
    @(negedge clk);
    hostCs = 1; hostAddr = 3'(DADDR); hostRd = 1;
    #1 d = hostRData;
    @(negedge clk);
    hostCs = 0; hostRd = 0;
  endtask

  task automatic dackRd(input bit withRd, output logic [7:0] d);
    @(negedge clk);
    dack = 1; hostAddr = 3'd7; hostRd = withRd;
    #1 d = hostRData;
    @(negedge clk);
    dack = 0; hostRd = 0;
  endtask

  task automatic take(output logic [7:0] d);
    @(negedge clk);
    serTake = 1;
    #1 d = serData;
    @(negedge clk);
    serTake = 0;
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    serPut = 1; serInData = d;
    @(negedge clk);
    serPut = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic [7:0] sect [SB];
    logic [15:0] crc;

    repeat (3) @(negedge clk);
    #1;
    check("R6 reset rqm", rqm, 0);
    check("R7 reset drq", drq, 0);
    check("R1 reset exec", execActive, 0);
    check("R11 reset result", resultPhase, 0);
    rstN = 1;

    // R1: stale bytes are flushed by a new command
    startCmd(0, 1, 0, 1, 0, 1);
    pioWr(8'hEE, 3'(DADDR)); pioWr(8'hEF, 3'(DADDR)); pioWr(8'hF0, 3'(DADDR));
    startCmd(0, 1, 0, 1, 0, 1);
    #1 check("R1 exec after start", execActive, 1);
    for (int i = 0; i < SB; i++) begin
      sect[i] = 8'(8'h30 + i);
      pioWr(sect[i], 3'(DADDR));
    end
    for (int i = 0; i < SB; i++) begin
      take(got);
      check("R1 R2 flushed data", got, sect[i]);
    end
    crc = crcOf(sect);
    take(got); check("R2 crc hi", got, crc[15:8]);
    take(got); check("R2 crc lo", got, crc[7:0]);
    #1 check("R11 result after crc", resultPhase, 1);
    check("R6 rqm in result", rqm, 0);

    // R2/R8/R11: multi-sector writes, alternating access paths
    for (int ns = 1; ns <= 3; ns++) begin
      startCmd(0, ns, 0, 1, 0, 1);
      for (int s = 0; s < ns; s++) begin
        for (int i = 0; i < SB; i++) begin
          sect[i] = 8'((ns * 37 + s * 11 + i * 7) & 255);
          if (i[0]) dackWr(sect[i]); else pioWr(sect[i], 3'(DADDR));
        end
        for (int i = 0; i < SB; i++) begin
          take(got);
          check("R2 R8 sector data", got, sect[i]);
        end
        crc = crcOf(sect);
        take(got); check("R2 sector crc hi", got, crc[15:8]);
        take(got); check("R2 sector crc lo", got, crc[7:0]);
        #1 check("R11 result timing", resultPhase, (s == ns - 1) ? 1 : 0);
      end
    end

    // R3: underrun at every data byte position
    for (int k = 0; k < SB; k++) begin
      startCmd(0, 2, 0, 1, 0, 1);
      for (int i = 0; i < SB; i++) sect[i] = (i < k) ? 8'(8'hA0 + i) : 8'h00;
      for (int i = 0; i < k; i++) pioWr(sect[i], 3'(DADDR));
      for (int i = 0; i < SB; i++) begin
        take(got);
        check("R3 underrun fill", got, sect[i]);
      end
      #1 check("R3 underrun flag", underrun, 1);
      check("R6 rqm after underrun", rqm, 0);
      pioWr(8'h55, 3'(DADDR));
      crc = crcOf(sect);
      take(got); check("R3 underrun crc hi", got, crc[15:8]);
      take(got); check("R3 underrun crc lo", got, crc[7:0]);
      #1 check("R3 result after sector", resultPhase, 1);
    end

    // R8: programmed I/O with a wrong address is ignored
    startCmd(0, 1, 0, 1, 0, 1);
    pioWr(8'h11, 3'd3);
    pioWr(8'h22, 3'(DADDR));
    take(got);
    check("R8 wrong address ignored", got, 8'h22);

    // R9/R6: byte mode holds one byte, extra write is ignored
    startCmd(0, 1, 0, 0, 0, 9);
    #1 check("R6 rqm write room", rqm, 1);
    check("R6 dio write", dio, 0);
    pioWr(8'hA1, 3'(DADDR));
    #1 check("R9 byte mode full rqm", rqm, 0);
    pioWr(8'hB2, 3'(DADDR));
    take(got); check("R9 R6 byte mode data", got, 8'hA1);
    #1 check("R6 rqm after take", rqm, 1);
    pioWr(8'hC3, 3'(DADDR));
    take(got); check("R9 byte mode second", got, 8'hC3);

    // R7: write drq with threshold 8, 24 bytes owed
    startCmd(0, 3, 1, 1, 0, 8);
    #1 check("R7 write drq initial", drq, 1);
    for (int i = 1; i <= 10; i++) begin
      dackWr(8'(i));
      #1 check("R7 write drq", drq, ((16 - i) >= ((24 - i) < 8 ? (24 - i) : 8)) ? 1 : 0);
    end
    // R7: write drq with threshold 4, drops when nothing more is owed
    startCmd(0, 1, 1, 1, 0, 4);
    for (int i = 1; i <= SB; i++) begin
      dackWr(8'(i));
      #1 check("R7 write drq owed", drq, (i < SB) ? 1 : 0);
    end

    // R7/R4: read drq sweep over thresholds, data order, result after drain
    for (int t = 0; t <= 16; t = (t == 0) ? 1 : t * 2) begin
      int thr;
      thr = (t == 0) ? 1 : t;
      startCmd(1, 2, 1, 1, 0, t);
      #1 check("R6 dio read", dio, 1);
      check("R7 read drq empty", drq, 0);
      for (int i = 1; i <= 16; i++) begin
        put(8'(t * 5 + i));
        #1 check("R7 read drq", drq, (i >= thr) ? 1 : 0);
      end
      for (int i = 1; i <= 16; i++) begin
        dackRd(1, got);
        check("R4 R8 read data", got, 8'(t * 5 + i));
      end
      settle();
      check("R4 read result", resultPhase, 1);
    end

    // R5: overrun in FIFO mode
    startCmd(1, 3, 0, 1, 0, 1);
    for (int i = 0; i < 17; i++) put(8'(8'h40 + i));
    #1 check("R5 overrun flag", overrun, 1);
    put(8'h99);
    settle();
    check("R5 result held", resultPhase, 0);
    for (int i = 0; i < 16; i++) begin
      pioRd(got);
      check("R5 drain data", got, 8'(8'h40 + i));
    end
    settle();
    check("R5 result after drain", resultPhase, 1);

    // R5/R9: overrun in byte mode
    startCmd(1, 1, 0, 0, 0, 1);
    put(8'h5A);
    put(8'h6B);
    #1 check("R5 R9 byte mode overrun", overrun, 1);
    check("R5 result before drain", resultPhase, 0);
    pioRd(got);
    check("R5 R9 byte mode drain", got, 8'h5A);
    settle();
    check("R5 byte mode result", resultPhase, 1);

    // R10: verify pseudo-reads
    startCmd(1, 1, 1, 0, 1, 1);
    for (int i = 0; i < SB; i++) begin
      put(8'(8'h70 + i));
      #1 check("R10 rqm byte ready", rqm, 1);
      dackRd(0, got);
      check("R10 pseudo read data", got, 8'h00);
      #1 check("R10 byte consumed", rqm, 0);
    end
    settle();
    check("R10 verify result", resultPhase, 1);
    check("R10 no overrun", overrun, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule